// File: doc/BRIEF.md
# Floating-Point Status Access Gate

This block decides, in a single combinational step, whether a software read or write of the floating-point status register may go ahead. It takes the privilege level of the access and the configuration that applies to it. This configuration covers whether levels 2 and 3 are present or enabled, the host-mode state seen from level 0 and level 2, the floating-point enable fields and trap bits of levels 1 to 3, a general redirect bit and two secure-debug-disable controls. The block returns exactly one verdict: allow, undefined instruction, or trap. A trap carries a target level and a syndrome class code.

The checks run in a fixed priority. That priority depends on the current level and on host mode, and the first check that matches sets the verdict. An access from level 0 can be redirected to level 2. Only that redirected trap uses the alternative class code. Every other trap uses the floating-point class code. Reads and writes pass the same checks. The direction input only chooses which of the two go strobes is raised when the verdict is allow. Exception entry and the register storage are outside the block.

Top module: `fp_status_access_gate`

## Requirements
- R1: At levels 0, 1 and 2, when level 3 is present, the undefined-priority debug-disable control is high and the level-3 trap bit is set, the verdict is undefined before any other check is made.
- R2: At level 0 without host mode, a level-1 enable field other than 2'b11 traps. The target is level 2 with class CLASS_REDIR (0x00) when level 2 is enabled and the redirect bit is high. Otherwise the target is level 1 with class CLASS_FP (0x07).
- R3: At level 0 in host mode, a level-2 enable field other than 2'b11 traps to level 2 with class 0x07.
- R4: At level 1, a level-1 enable field with bit 0 low traps to level 1 with class 0x07.
- R5: When level 2 is in host mode, a level-2 enable field with bit 0 low traps to level 2 with class 0x07. When level 2 is not in host mode, a set level-2 trap bit traps to level 2 with class 0x07. At levels 0 and 1 this trap needs level 2 to be enabled; at level 2 it does not.
- R6: At levels 0 to 2 the level-3 trap bit is checked last and only when level 3 is present. It gives undefined when the debug-disable-undefined control is high, and a trap to level 3 with class 0x07 otherwise.
- R7: At level 3 the only check is the level-3 trap bit. It traps to level 3 with class 0x07 regardless of every other input; otherwise the access is allowed.
- R8: Exactly one of allow, undef and trap is high. The target level and class outputs are zero unless trap is high.
- R9: Reads (is_write=0) and writes (is_write=1) get the same verdict. rd_go follows allow for reads and wr_go follows allow for writes, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_lvl | input | 2 | Privilege level of the access, 0 to 3 |
| is_write | input | 1 | 1 for a write, 0 for a read |
| lvl2_on | input | 1 | Level 2 is enabled for the current state |
| lvl3_here | input | 1 | Level 3 is implemented |
| host_at_lvl0 | input | 1 | Level 0 runs under a host-mode level 2 |
| host_at_lvl2 | input | 1 | Level 2 runs in host mode |
| l1_fp_en | input | 2 | Level-1 floating-point access enable field |
| l2_fp_en | input | 2 | Level-2 floating-point enable field (host mode) |
| l2_fp_trap | input | 1 | Level-2 floating-point trap bit |
| l3_fp_trap | input | 1 | Level-3 floating-point trap bit |
| redirect | input | 1 | General trap redirect from level 1 to level 2 |
| sdd_undef_prio | input | 1 | Debug-disable control that makes undefined take top priority |
| sdd_undef | input | 1 | Debug-disable control that turns the final level-3 trap into undefined |
| allow | output | 1 | Access proceeds |
| undef | output | 1 | Undefined instruction |
| trap | output | 1 | Access traps |
| trap_lvl | output | 2 | Target level of the trap, zero otherwise |
| trap_class | output | CLASS_W | Syndrome class of the trap, zero otherwise |
| rd_go | output | 1 | Allowed read proceeds |
| wr_go | output | 1 | Allowed write proceeds |

## Verification
The bench builds the gate with its default parameters: a 6-bit class field, 0x07 for floating-point traps and 0x00 for the redirected trap. With these values the two class codes differ, so the redirected trap can be told apart from every other trap. The input space has sixteen bits and no parameter scales it, so the bench applies every combination. This includes the cases where host-mode and non-host checks, the final level-3 check and the top-priority undefined check compete, and each verdict is tagged with the rule that should have decided it.

// File: rtl/fp_status_access_gate.sv
module fp_status_access_gate #(
  parameter int unsigned CLASS_W     = 6,
  parameter int unsigned CLASS_FP    = 7,
  parameter int unsigned CLASS_REDIR = 0
) (
  input  logic [1:0]         cur_lvl,
  input  logic               is_write,
  input  logic               lvl2_on,
  input  logic               lvl3_here,
  input  logic               host_at_lvl0,
  input  logic               host_at_lvl2,
  input  logic [1:0]         l1_fp_en,
  input  logic [1:0]         l2_fp_en,
  input  logic               l2_fp_trap,
  input  logic               l3_fp_trap,
  input  logic               redirect,
  input  logic               sdd_undef_prio,
  input  logic               sdd_undef,
  output logic               allow,
  output logic               undef,
  output logic               trap,
  output logic [1:0]         trap_lvl,
  output logic [CLASS_W-1:0] trap_class,
  output logic               rd_go,
  output logic               wr_go
);
  localparam logic [CLASS_W-1:0] C_FP    = CLASS_FP[CLASS_W-1:0];
  localparam logic [CLASS_W-1:0] C_REDIR = CLASS_REDIR[CLASS_W-1:0];

  logic prio_undef, l2_bit_hit, l2_host_off, l3_tail;
  logic hit_undef, hit_trap;
  logic [1:0] tgt;
  logic [CLASS_W-1:0] cls;

  assign prio_undef  = lvl3_here && sdd_undef_prio && l3_fp_trap;
  assign l2_bit_hit  = !host_at_lvl2 && l2_fp_trap;
  assign l2_host_off = host_at_lvl2 && !l2_fp_en[0];
  assign l3_tail     = lvl3_here && l3_fp_trap;

  always_comb begin
    hit_undef = 1'b0;
    hit_trap  = 1'b0;
    tgt       = 2'd0;
    cls       = '0;
    if (cur_lvl == 2'd3) begin
      if (l3_fp_trap) begin
        hit_trap = 1'b1; tgt = 2'd3; cls = C_FP;
      end
    end else if (prio_undef) begin
      hit_undef = 1'b1;
    end else if (cur_lvl == 2'd0 && !host_at_lvl0 && l1_fp_en != 2'b11) begin
      hit_trap = 1'b1;
      if (lvl2_on && redirect) begin
        tgt = 2'd2; cls = C_REDIR;
      end else begin
        tgt = 2'd1; cls = C_FP;
      end
    end else if (cur_lvl == 2'd0 && host_at_lvl0 && l2_fp_en != 2'b11) begin
      hit_trap = 1'b1; tgt = 2'd2; cls = C_FP;
    end else if (cur_lvl == 2'd1 && !l1_fp_en[0]) begin
      hit_trap = 1'b1; tgt = 2'd1; cls = C_FP;
    end else if (l2_host_off || (l2_bit_hit && (lvl2_on || cur_lvl == 2'd2))) begin
      hit_trap = 1'b1; tgt = 2'd2; cls = C_FP;
    end else if (l3_tail) begin
      if (sdd_undef) hit_undef = 1'b1;
      else begin
        hit_trap = 1'b1; tgt = 2'd3; cls = C_FP;
      end
    end
  end

  assign undef      = hit_undef;
  assign trap       = hit_trap;
  assign allow      = !hit_undef && !hit_trap;
  assign trap_lvl   = tgt;
  assign trap_class = cls;
  assign rd_go      = allow && !is_write;
  assign wr_go      = allow && is_write;

  always_comb begin
    assert_one_verdict_R8: assert ($countones({allow, undef, trap}) == 1);
    assert_quiet_fields_R8: assert (trap || (trap_lvl == 2'd0 && trap_class == '0));
    assert_prio_undef_R1: assert (!(cur_lvl != 2'd3 && prio_undef) || undef);
    assert_top_level_R7: assert (cur_lvl != 2'd3 || (!undef && trap == l3_fp_trap));
    assert_go_strobes_R9: assert (!(rd_go && wr_go) && ((rd_go || wr_go) == allow));
    assert_redir_only_lvl0_R2: assert (!(trap && trap_lvl == 2'd2 && trap_class == C_REDIR
                                        && C_REDIR != C_FP) || cur_lvl == 2'd0);
  end
endmodule

// File: tb/fp_status_access_gate_tb.sv
module fp_status_access_gate_tb;
  typedef struct {
    logic [1:0] kind;
    logic [1:0] lvl;
    logic [5:0] cls;
    logic       wr;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [15:0] vec = '0;
  logic allow, undef, trap, rd_go, wr_go;
  logic [1:0] trap_lvl;
  logic [5:0] trap_class;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit driving = 1'b1;
  exp_t q[$];

  fp_status_access_gate #(.CLASS_W(6), .CLASS_FP(7), .CLASS_REDIR(0)) u_dut (
    .cur_lvl(vec[1:0]), .is_write(vec[2]), .lvl2_on(vec[3]), .lvl3_here(vec[4]),
    .host_at_lvl0(vec[5]), .host_at_lvl2(vec[6]), .l1_fp_en(vec[8:7]),
    .l2_fp_en(vec[10:9]), .l2_fp_trap(vec[11]), .l3_fp_trap(vec[12]),
    .redirect(vec[13]), .sdd_undef_prio(vec[14]), .sdd_undef(vec[15]),
    .allow(allow), .undef(undef), .trap(trap), .trap_lvl(trap_lvl),
    .trap_class(trap_class), .rd_go(rd_go), .wr_go(wr_go)
  );

  function automatic exp_t model(input logic [15:0] v);
    exp_t e;
    logic [1:0] lv = v[1:0];
    logic l2 = v[3], h3 = v[4], hst0 = v[5], hst2 = v[6];
    logic [1:0] f1 = v[8:7];
    logic [1:0] f2 = v[10:9];
    logic t2 = v[11], t3 = v[12], rd = v[13], sp = v[14], su = v[15];
    e.kind = 2'd0; e.lvl = 2'd0; e.cls = 6'd0; e.wr = v[2]; e.req = "R9";
    if (lv == 2'd3) begin
      e.req = "R7";
      if (t3) begin e.kind = 2'd2; e.lvl = 2'd3; e.cls = 6'd7; end
      return e;
    end
    if (h3 && sp && t3) begin e.kind = 2'd1; e.req = "R1"; return e; end
    if (lv == 2'd0 && !hst0 && f1 != 2'b11) begin
      e.kind = 2'd2; e.req = "R2";
      if (l2 && rd) begin e.lvl = 2'd2; e.cls = 6'd0; end
      else begin e.lvl = 2'd1; e.cls = 6'd7; end
      return e;
    end
    if (lv == 2'd0 && hst0 && f2 != 2'b11) begin
      e.kind = 2'd2; e.lvl = 2'd2; e.cls = 6'd7; e.req = "R3"; return e;
    end
    if (lv == 2'd1 && !f1[0]) begin
      e.kind = 2'd2; e.lvl = 2'd1; e.cls = 6'd7; e.req = "R4"; return e;
    end
    if ((hst2 && !f2[0]) || (!hst2 && t2 && (l2 || lv == 2'd2))) begin
      e.kind = 2'd2; e.lvl = 2'd2; e.cls = 6'd7; e.req = "R5"; return e;
    end
    if (h3 && t3) begin
      e.req = "R6";
      if (su) e.kind = 2'd1;
      else begin e.kind = 2'd2; e.lvl = 2'd3; e.cls = 6'd7; end
    end
    return e;
  endfunction

  task automatic report(input string req, input string what, input int act, input int exp_v);
    fails++;
    if (fails <= 20)
      $display("FAIL %s %s vec=%h actual=%0d expected=%0d", req, what, vec, act, exp_v);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    for (int v = 0; v < 65536; v++) begin
      @(posedge clk);
      #1;
      vec = v[15:0];
      q.push_back(model(v[15:0]));
    end
    driving = 1'b0;
  end

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      logic [1:0] got;
      e = q.pop_front();
      got = trap ? 2'd2 : (undef ? 2'd1 : 2'd0);
      checks++;
      if (got != e.kind) report(e.req, "verdict", got, e.kind);
      checks++;
      if (trap_lvl != e.lvl || trap_class != e.cls)
        report(e.req, "lvl/class", {trap_lvl, trap_class}, {e.lvl, e.cls});
      checks++;
      if ($countones({allow, undef, trap}) != 1 || (!trap && (trap_lvl != 0 || trap_class != 0)))
        report("R8", "exclusive", {allow, undef, trap}, 0);
      checks++;
      if (rd_go != (e.kind == 2'd0 && !e.wr) || wr_go != (e.kind == 2'd0 && e.wr))
        report("R9", "go strobes", {rd_go, wr_go}, {(e.kind == 2'd0 && !e.wr), (e.kind == 2'd0 && e.wr)});
      if (!driving && q.size() == 0) begin
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cycles, 65540);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule